// File: doc/BRIEF.md
# SDRAM Refresh Command Arbiter

This block decides when auto-refresh commands reach an SDRAM command bus. Refresh can come from two sources. In user-control mode the request comes from user logic. In timer mode an internal interval counter raises it. When a refresh is due, the block stops granting new reads and writes. It waits until any transfer already in flight has finished. Then it issues a precharge-all command followed by an auto-refresh command, and a counter enforces the recovery time after each one.

Each auto-refresh pulses an acknowledge for one cycle, in both modes, so user logic can always track refresh activity. In user mode, a request that stays high chains further auto-refreshes with no new precharge between them. This lets user logic pack a burst of refreshes into an idle period. When the request drops, the grant to pending reads and writes comes back.

Top module: `refresh_cmd_arbiter`

## Requirements
- R1: While `rstN` is sampled low at a clock edge, the command bus is driven to NOP and `refreshAck` is held low. All wait and interval counters restart from their initial values.
- R2: `xferGrant` is high only when the arbiter is idle, no refresh is pending and `rdReq` or `wrReq` is high. A pending refresh removes the grant whatever the read and write request lines are doing.
- R3: While `xferBusy` is high, no precharge is issued. The sequence starts at the first edge at which a refresh is pending and `xferBusy` is low.
- R4: Commands are encoded on {csN, rasN, casN, weN} as NOP = 0111, precharge = 0010 and auto-refresh = 0001. The sequence is a precharge with address bit 10 high and every other address and bank bit low, followed by an auto-refresh with address and bank zero.
- R5: The auto-refresh follows its precharge exactly TRP cycles later.
- R6: `refreshAck` is high for exactly the cycle in which an auto-refresh command is on the bus, and low in every other cycle.
- R7: In user mode, if `refreshReq` is high when the TRFC recovery after an auto-refresh ends, another auto-refresh is issued TRFC cycles after the previous one, with no precharge between them.
- R8: With `userCtrlEn` low, `refreshReq` is ignored. An internal request is raised every TREFI cycles, and it clears when its auto-refresh is issued.
- R9: In user mode, once `refreshReq` is low at the end of the TRFC recovery, the arbiter goes idle and `xferGrant` follows `rdReq`/`wrReq` again.
- R10: NOP is driven in every cycle in which no precharge or auto-refresh is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| userCtrlEn | input | 1 | 1: refresh driven by `refreshReq`; 0: internal interval timer |
| refreshReq | input | 1 | User refresh request, held high to chain refreshes |
| rdReq | input | 1 | A read is waiting for the bus |
| wrReq | input | 1 | A write is waiting for the bus |
| xferBusy | input | 1 | A read or write transfer is still in flight |
| xferGrant | output | 1 | Reads and writes may proceed |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (bit 10 marks precharge-all) |
| bank | output | BANK_W | Bank address, always zero here |
| refreshAck | output | 1 | One-cycle pulse per auto-refresh |

## Verification
The bench builds the block with TRP = 2, TRFC = 5 and TREFI = 40. These short recovery windows keep the precharge spacing and the chaining boundary within a few cycles. The short interval lets several timer-driven refreshes happen in a short run. With these values the bench can hit a request that drops just as the recovery window ends, as well as an interval that expires while a transfer is still busy.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PRE_WAIT = 2'd1,
    ST_ARF_WAIT = 2'd2
  } arbState_t;

  typedef struct packed {
    logic issuePre;
    logic issueArf;
  } ctlStrobe_t;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_ARF = 4'b0001;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_pkg::*;
#(
  parameter int TRP    = 3,
  parameter int TRFC   = 20,
  parameter int TREFI  = 1560,
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              userCtrlEn,
  input  ctlStrobe_t        ctl,
  output logic              waitDone,
  output logic              timerReq,
  output logic [3:0]        cmdBits,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              refreshAck
);

  localparam int WAIT_MAX = (TRP > TRFC) ? TRP : TRFC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int TMR_W    = $clog2(TREFI + 1);
  localparam int PALL_BIT = 10;

  logic [WAIT_W-1:0] waitCnt;
  logic [TMR_W-1:0]  intervalCnt;

  // recovery counter: loaded on each command, counts down to zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (ctl.issuePre) begin
      waitCnt <= WAIT_W'(TRP - 1);
    end else if (ctl.issueArf) begin
      waitCnt <= WAIT_W'(TRFC - 1);
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitDone = (waitCnt == '0);

  // interval timer for internally generated refreshes
  always_ff @(posedge clk) begin
    if (!rstN || userCtrlEn) begin
      intervalCnt <= TMR_W'(TREFI - 1);
      timerReq    <= 1'b0;
    end else begin
      if (intervalCnt == '0) begin
        intervalCnt <= TMR_W'(TREFI - 1);
      end else begin
        intervalCnt <= intervalCnt - 1'b1;
      end
      if (intervalCnt == '0) begin
        timerReq <= 1'b1;
      end else if (ctl.issueArf) begin
        timerReq <= 1'b0;
      end
    end
  end

  // command, address and acknowledge registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdBits    <= CMD_NOP;
      addr       <= '0;
      refreshAck <= 1'b0;
    end else begin
      refreshAck <= ctl.issueArf;
      if (ctl.issuePre) begin
        cmdBits <= CMD_PRE;
        addr    <= ADDR_W'(1) << PALL_BIT;
      end else if (ctl.issueArf) begin
        cmdBits <= CMD_ARF;
        addr    <= '0;
      end else begin
        cmdBits <= CMD_NOP;
        addr    <= '0;
      end
    end
  end

  assign bank = '0;

  // R6: acknowledge and auto-refresh command share the same cycle
  a_r6_ack_with_arf: assert property (@(posedge clk) disable iff (!rstN)
    refreshAck |-> (cmdBits == CMD_ARF));

  // R4: precharge-all carries only address bit 10
  a_r4_pre_addr: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits == CMD_PRE) |-> (addr == (ADDR_W'(1) << PALL_BIT)));

  // R7: a precharge is never followed directly by another precharge
  a_r7_no_double_pre: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits == CMD_PRE) |=> (cmdBits != CMD_PRE));

  // R10: only the three legal encodings appear on the bus
  a_r10_legal_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits == CMD_NOP) || (cmdBits == CMD_PRE) || (cmdBits == CMD_ARF));

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       userCtrlEn,
  input  logic       refreshReq,
  input  logic       rdReq,
  input  logic       wrReq,
  input  logic       xferBusy,
  input  logic       waitDone,
  input  logic       timerReq,
  output ctlStrobe_t ctl,
  output logic       xferGrant
);

  arbState_t state, stateNext;
  logic      pending;

  assign pending = userCtrlEn ? refreshReq : timerReq;

  always_comb begin
    stateNext    = state;
    ctl          = '0;
    unique case (state)
      ST_IDLE: begin
        if (pending && !xferBusy) begin
          ctl.issuePre = 1'b1;
          stateNext    = ST_PRE_WAIT;
        end
      end
      ST_PRE_WAIT: begin
        if (waitDone) begin
          ctl.issueArf = 1'b1;
          stateNext    = ST_ARF_WAIT;
        end
      end
      ST_ARF_WAIT: begin
        if (waitDone) begin
          if (pending) begin
            ctl.issueArf = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign xferGrant = (state == ST_IDLE) && !pending && (rdReq || wrReq);

  // R3: an in-flight transfer always blocks the precharge
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy |-> !ctl.issuePre);

  // R5: no auto-refresh while precharge recovery is still counting
  a_r5_trp_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PRE_WAIT) && !waitDone) |-> !ctl.issueArf);

  // R2: the grant is withdrawn while a refresh is pending
  a_r2_no_grant_pending: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !xferGrant);

  // R7: chained refreshes never pass through another precharge
  a_r7_chain_no_pre: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARF_WAIT) |-> !ctl.issuePre);

endmodule

// File: rtl/refresh_cmd_arbiter.sv
module refresh_cmd_arbiter
  import refresh_pkg::*;
#(
  parameter int TRP    = 3,
  parameter int TRFC   = 20,
  parameter int TREFI  = 1560,
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              userCtrlEn,
  input  logic              refreshReq,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic              xferBusy,
  output logic              xferGrant,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              refreshAck
);

  ctlStrobe_t ctl;
  logic       waitDone;
  logic       timerReq;
  logic [3:0] cmdBits;

  refresh_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .userCtrlEn (userCtrlEn),
    .refreshReq (refreshReq),
    .rdReq      (rdReq),
    .wrReq      (wrReq),
    .xferBusy   (xferBusy),
    .waitDone   (waitDone),
    .timerReq   (timerReq),
    .ctl        (ctl),
    .xferGrant  (xferGrant)
  );

  refresh_datapath #(
    .TRP    (TRP),
    .TRFC   (TRFC),
    .TREFI  (TREFI),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .userCtrlEn (userCtrlEn),
    .ctl        (ctl),
    .waitDone   (waitDone),
    .timerReq   (timerReq),
    .cmdBits    (cmdBits),
    .addr       (addr),
    .bank       (bank),
    .refreshAck (refreshAck)
  );

  assign {csN, rasN, casN, weN} = cmdBits;

endmodule

// File: tb/sim_refresh_cmd_arbiter.sv
module sim_refresh_cmd_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int TRP    = 2;
  localparam int TRFC   = 5;
  localparam int TREFI  = 40;
  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic userCtrlEn = 1'b1;
  logic refreshReq = 1'b0;
  logic rdReq = 1'b0;
  logic wrReq = 1'b0;
  logic xferBusy = 1'b0;
  logic xferGrant, csN, rasN, casN, weN, refreshAck;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] bank;

  refresh_cmd_arbiter #(
    .TRP(TRP), .TRFC(TRFC), .TREFI(TREFI), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .userCtrlEn(userCtrlEn), .refreshReq(refreshReq),
    .rdReq(rdReq), .wrReq(wrReq), .xferBusy(xferBusy), .xferGrant(xferGrant),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .addr(addr), .bank(bank),
    .refreshAck(refreshAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model state
  int mPhase = 0;        // 0 idle, 1 precharge recovery, 2 refresh recovery
  int mReadyAt = 0;
  int mTimerLeft = TREFI;
  bit mTimerReq = 1'b0;
  logic [3:0] expCmd = 4'b0111;
  logic [ADDR_W-1:0] expAddr = '0;
  bit expAck = 1'b0;

  // event tallies
  int preCount = 0;
  int arfCount = 0;
  int lastPreCyc = 0;
  int lastArfCyc = 0;
  int lastGap = 0;
  int lastArfGap = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    bit pend, clr;
    cyc++;
    pend = userCtrlEn ? refreshReq : mTimerReq;
    expCmd = 4'b0111;
    expAddr = '0;
    expAck = 1'b0;
    clr = 1'b0;
    if (!rstN) begin
      mPhase = 0;
      mTimerLeft = TREFI;
      mTimerReq = 1'b0;
    end else begin
      case (mPhase)
        0: if (pend && !xferBusy) begin
             expCmd = 4'b0010;
             expAddr = ADDR_W'(1) << 10;
             mPhase = 1;
             mReadyAt = cyc + TRP;
           end
        1: if (cyc >= mReadyAt) begin
             expCmd = 4'b0001;
             expAck = 1'b1;
             clr = 1'b1;
             mPhase = 2;
             mReadyAt = cyc + TRFC;
           end
        default: if (cyc >= mReadyAt) begin
             if (pend) begin
               expCmd = 4'b0001;
               expAck = 1'b1;
               clr = 1'b1;
               mReadyAt = cyc + TRFC;
             end else begin
               mPhase = 0;
             end
           end
      endcase
      if (userCtrlEn) begin
        mTimerLeft = TREFI;
        mTimerReq = 1'b0;
      end else begin
        if (clr) mTimerReq = 1'b0;
        mTimerLeft--;
        if (mTimerLeft == 0) begin
          mTimerReq = 1'b1;
          mTimerLeft = TREFI;
        end
      end
    end
  end

  // compare one time unit after each edge; inputs only change on the falling edge
  always @(posedge clk) begin
    bit expGrant;
    #1;
    if (!done) begin
      expGrant = (mPhase == 0) && !(userCtrlEn ? refreshReq : mTimerReq) && (rdReq || wrReq);
      check({csN, rasN, casN, weN} == expCmd, "R4/R10 cmd", int'({csN, rasN, casN, weN}), int'(expCmd));
      check(addr == expAddr && bank == '0, "R4 addr", int'(addr), int'(expAddr));
      check(refreshAck == expAck, "R6 ack", int'(refreshAck), int'(expAck));
      check(xferGrant == expGrant, "R2 grant", int'(xferGrant), int'(expGrant));
      if ({csN, rasN, casN, weN} == 4'b0010) begin
        preCount++;
        lastPreCyc = cyc;
      end
      if ({csN, rasN, casN, weN} == 4'b0001) begin
        arfCount++;
        lastGap = cyc - lastPreCyc;
        lastArfGap = cyc - lastArfCyc;
        lastArfCyc = cyc;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitAck();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (refreshAck) return;
    end
  endtask

  initial begin
    int p0, a0;
    // R1: reset state
    cycles(3);
    check({csN, rasN, casN, weN} == 4'b0111 && !refreshAck, "R1 reset", int'({csN, rasN, casN, weN}), 7);
    rstN = 1'b1;
    cycles(2);

    // R2: grant follows rd/wr with nothing pending
    rdReq = 1'b1; cycles(1);
    check(xferGrant == 1'b1, "R2 grant rd", int'(xferGrant), 1);
    rdReq = 1'b0; wrReq = 1'b1; cycles(1);
    check(xferGrant == 1'b1, "R2 grant wr", int'(xferGrant), 1);

    // R3: busy transfer holds off precharge, request removes grant
    p0 = preCount;
    xferBusy = 1'b1; refreshReq = 1'b1; rdReq = 1'b1;
    cycles(1);
    check(xferGrant == 1'b0, "R2 pending blocks grant", int'(xferGrant), 0);
    cycles(6);
    check(preCount == p0, "R3 no precharge while busy", preCount - p0, 0);
    xferBusy = 1'b0;
    waitAck();
    // R5: gap between precharge and auto-refresh
    check(lastGap == TRP, "R5 precharge spacing", lastGap, TRP);
    refreshReq = 1'b0;
    cycles(TRFC + 2);
    // R9: grant returns once request is dropped
    check(xferGrant == 1'b1, "R9 grant back", int'(xferGrant), 1);

    // R7: chained refreshes
    p0 = preCount; a0 = arfCount;
    refreshReq = 1'b1;
    waitAck(); waitAck(); waitAck();
    refreshReq = 1'b0;
    check(lastArfGap == TRFC, "R7 chain spacing", lastArfGap, TRFC);
    cycles(TRFC + 3);
    check(preCount - p0 == 1, "R7 single precharge", preCount - p0, 1);
    check(arfCount - a0 == 3, "R7 three refreshes", arfCount - a0, 3);

    // request dropped right at the end of recovery
    refreshReq = 1'b1;
    waitAck();
    cycles(TRFC - 1);
    refreshReq = 1'b0;
    cycles(4);
    check(xferGrant == 1'b1, "R9 late drop", int'(xferGrant), 1);

    // R8: timer mode, refreshReq ignored
    rstN = 1'b0; cycles(2);
    userCtrlEn = 1'b0; rstN = 1'b1;
    a0 = arfCount;
    for (int i = 0; i < 6 * TREFI; i++) begin
      @(negedge clk);
      refreshReq = (i % 7) < 3;
      rdReq = (i % 5) != 0;
      xferBusy = (i % 53) < 9;
    end
    refreshReq = 1'b0; xferBusy = 1'b0;
    cycles(TRFC + TRP + 4);
    check(arfCount - a0 == 6, "R8 timer refresh count", arfCount - a0, 6);

    // R1: reset mid-sequence
    userCtrlEn = 1'b1; refreshReq = 1'b1;
    cycles(3);
    rstN = 1'b0; refreshReq = 1'b0;
    cycles(1);
    check({csN, rasN, casN, weN} == 4'b0111 && !refreshAck, "R1 reset mid-sequence", int'({csN, rasN, casN, weN}), 7);
    rstN = 1'b1;
    cycles(5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule